// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the interrupt bookkeeping for one processor: a 256-bit set of requested vectors, a 256-bit set of vectors in service and a 256-bit set of trigger-mode flags. A vector number is its own priority, and the upper nibble of a vector is its priority class. The core works out a processor priority from a task-priority byte and the highest vector in service. It raises a registered interrupt line when the highest requested vector is in a class above that priority.

The processor acknowledges with a one-cycle strobe. One cycle later the core answers with a vector and moves that vector from the requested set to the in-service set. If a request is pending but held off by the processor priority, the answer is the spurious vector and nothing changes. If nothing can be delivered, a "none" flag is returned. An end-of-interrupt strobe retires the highest vector in service. When that vector was level-triggered and broadcast suppression is off, the core pulses a broadcast output carrying the retired vector.

The core is configured through a 16-bit configuration write and two ways of writing the task priority: a full byte, or a short 4-bit class value.

Top module: `vec_prio_core`

## Requirements
- R1: After reset all three vector sets are empty, the task priority is 0, the spurious vector is 0xFF, software enable and suppress are 0, `irq_o` is 0, `ppr_o` is 0 and no response or broadcast pulse is active. The highest vector in a set is its highest-numbered set bit.
- R2: `ppr_o` equals the task-priority byte when its upper nibble is at least the class (upper nibble) of the highest in-service vector. Otherwise it equals that class in the upper nibble with a zero lower nibble. An empty in-service set counts as class 0.
- R3: While the software-enable bit (configuration bit 8) is 0, `irq_o` stays low and an acknowledge returns `ack_none_o`=1 and changes no state.
- R4: When `ppr_o` is nonzero and the class of the highest requested vector is less than or equal to `ppr_o[7:4]`, the request is held off. An acknowledge then returns `ack_none_o`=0 with `ack_vec_o` equal to the spurious vector (configuration bits 7:0), and changes no state.
- R5: When a request is deliverable, an acknowledge returns the highest requested vector with `ack_none_o`=0, clears its requested bit and sets its in-service bit. The response is valid for exactly the one cycle after the strobe.
- R6: An accepted vector sets its requested bit, sets its trigger-mode bit when `req_level_i`=1 (level) and clears it when `req_level_i`=0 (edge).
- R7: End-of-interrupt clears the highest in-service bit. If that vector's trigger-mode bit is 1 and the suppress bit (configuration bit 12) is 0, `eoi_bc_valid_o` pulses for one cycle, the cycle after the strobe, with `eoi_bc_vec_o` equal to the vector.
- R8: End-of-interrupt with an empty in-service set changes no state and raises no broadcast.
- R9: A short task-priority write stores its 4-bit value in the upper nibble of the task-priority byte with a zero lower nibble. A full write stores the whole byte and wins when both are strobed together.
- R10: `irq_o` is registered. It is high exactly one cycle after the sets, task priority or enable reach a state in which the highest request is deliverable.
- R11: Within one cycle, end-of-interrupt and acknowledge act on the state before the edge, and an accepted vector is applied after them. So accepting the vector being acknowledged leaves it both requested and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Accept a vector this cycle |
| req_vec_i | input | 8 | Vector being accepted |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_wr_i | input | 1 | Full task-priority write |
| tpr_data_i | input | 8 | Full task-priority value |
| tpr_cls_wr_i | input | 1 | Short task-priority write |
| tpr_cls_i | input | 4 | Short task-priority class |
| cfg_wr_i | input | 1 | Configuration write |
| cfg_data_i | input | 16 | [7:0] spurious vector, [8] software enable, [12] broadcast suppress |
| irq_o | output | 1 | Interrupt request to the processor |
| ppr_o | output | 8 | Current processor priority |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_none_o | output | 1 | Response carries no vector |
| ack_vec_o | output | 8 | Returned vector |
| eoi_bc_valid_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vec_o | output | 8 | Broadcast vector |

## Verification
The bench sweeps every vector through accept, acknowledge and retire, and crosses every task-priority class with every request class. An off-by-one in the class comparison would deliver or hold off at exactly the equal-class boundary. Nested vectors in different classes are acknowledged and retired in turn. A design that retired the lowest in-service vector, or that ignored the in-service class when computing the priority, would return the wrong vector or raise the interrupt early. Level versus edge flags, the suppress bit, retiring with an empty in-service set and a same-cycle accept during an acknowledge are each checked. These catch a design that broadcasts for edge vectors, corrupts state on an empty retire, or lets the acknowledge clear a freshly accepted bit.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the vectored interrupt priority core.
// Assumes an 8-bit vector space; the class is the upper nibble.
package vpc_pkg;
    parameter int VW        = 8;
    parameter int NUM_VEC   = 1 << VW;
    parameter int CFG_EN    = 8;
    parameter int CFG_SUP   = 12;
    parameter logic [7:0] SPV_RESET = 8'hFF;
endpackage

// File: rtl/vpc_hi_find.sv
`timescale 1ns/1ps
// Module: vpc_hi_find
// Finds the highest-numbered set bit of a wide vector that is split into
// words. Purely combinational. Assumes WBITS is a power of two.
module vpc_hi_find #(
    parameter int WORDS = 8,
    parameter int WBITS = 32,
    localparam int IW   = $clog2(WORDS * WBITS),
    localparam int LW   = $clog2(WBITS)
) (
    input  logic [WORDS*WBITS-1:0] bits_i,
    output logic                   found_o,
    output logic [IW-1:0]          idx_o
);
    logic [WORDS-1:0] word_any;
    logic [LW-1:0]    word_msb [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Per-word OR and most-significant-bit index.
        always_comb begin
            word_any[w] = |bits_i[w*WBITS +: WBITS];
            word_msb[w] = '0;
            for (int b = 0; b < WBITS; b++) begin
                if (bits_i[w*WBITS + b]) word_msb[w] = LW'(b);
            end
        end
    end

    // Word-level scan: a higher occupied word overrides a lower one.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_any[w]) begin
                found_o = 1'b1;
                idx_o   = IW'(w * WBITS) + IW'(word_msb[w]);
            end
        end
    end
endmodule

// File: rtl/vpc_arbiter.sv
`timescale 1ns/1ps
// Module: vpc_arbiter
// Derives the processor priority from the task priority and the highest
// in-service vector, and classifies the highest request as deliverable,
// held off or absent. Combinational; assumes 8-bit vectors.
module vpc_arbiter (
    input  logic       sw_en_i,
    input  logic [7:0] tpr_i,
    input  logic       irr_found_i,
    input  logic [7:0] irr_hi_i,
    input  logic       isr_found_i,
    input  logic [7:0] isr_hi_i,
    output logic [7:0] ppr_o,
    output logic       deliver_o,
    output logic       held_o
);
    logic [3:0] isr_cls;

    // Processor priority: task priority or in-service class, whichever is higher.
    always_comb begin
        isr_cls = isr_found_i ? isr_hi_i[7:4] : 4'h0;
        ppr_o   = (tpr_i[7:4] >= isr_cls) ? tpr_i : {isr_cls, 4'h0};
    end

    // Request classification against the processor priority.
    always_comb begin
        deliver_o = 1'b0;
        held_o    = 1'b0;
        if (sw_en_i && irr_found_i) begin
            if (ppr_o != 8'h00 && irr_hi_i[7:4] <= ppr_o[7:4]) held_o = 1'b1;
            else                                             deliver_o = 1'b1;
        end
    end
endmodule

// File: rtl/vec_prio_core.sv
`timescale 1ns/1ps
// Module: vec_prio_core
// Requested / in-service / trigger-mode vector sets with priority-based
// delivery, acknowledge, end-of-interrupt and level broadcast.
// Assumes at most one owner drives each strobe; same-cycle events follow R11.
module vec_prio_core
    import vpc_pkg::*;
#(
    parameter int WBITS = 32,
    localparam int WORDS = NUM_VEC / WBITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [VW-1:0] req_vec_i,
    input  logic          req_level_i,
    input  logic          ack_i,
    input  logic          eoi_i,
    input  logic          tpr_wr_i,
    input  logic [7:0]    tpr_data_i,
    input  logic          tpr_cls_wr_i,
    input  logic [3:0]    tpr_cls_i,
    input  logic          cfg_wr_i,
    input  logic [15:0]   cfg_data_i,
    output logic          irq_o,
    output logic [7:0]    ppr_o,
    output logic          ack_valid_o,
    output logic          ack_none_o,
    output logic [VW-1:0] ack_vec_o,
    output logic          eoi_bc_valid_o,
    output logic [VW-1:0] eoi_bc_vec_o
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [7:0]         tpr_q, spv_q;
    logic               en_q, sup_q;
    logic               irr_found, isr_found;
    logic [VW-1:0]      irr_hi, isr_hi;
    logic               deliver, held;

    vpc_hi_find #(.WORDS(WORDS), .WBITS(WBITS)) i_irr_find (
        .bits_i(irr_q), .found_o(irr_found), .idx_o(irr_hi));

    vpc_hi_find #(.WORDS(WORDS), .WBITS(WBITS)) i_isr_find (
        .bits_i(isr_q), .found_o(isr_found), .idx_o(isr_hi));

    vpc_arbiter i_arb (
        .sw_en_i(en_q), .tpr_i(tpr_q),
        .irr_found_i(irr_found), .irr_hi_i(irr_hi),
        .isr_found_i(isr_found), .isr_hi_i(isr_hi),
        .ppr_o(ppr_o), .deliver_o(deliver), .held_o(held));

    // Next-state of the vector sets: retire, then acknowledge, then accept.
    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        if (eoi_i && isr_found) isr_n[isr_hi] = 1'b0;
        if (ack_i && deliver) begin
            irr_n[irr_hi] = 1'b0;
            isr_n[irr_hi] = 1'b1;
        end
        if (req_valid_i) begin
            irr_n[req_vec_i] = 1'b1;
            tmr_n[req_vec_i] = req_level_i;
        end
    end

    // Vector set registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            tmr_q <= tmr_n;
        end
    end

    // Task priority and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= 8'h00;
            spv_q <= SPV_RESET;
            en_q  <= 1'b0;
            sup_q <= 1'b0;
        end else begin
            if (tpr_wr_i)          tpr_q <= tpr_data_i;
            else if (tpr_cls_wr_i) tpr_q <= {tpr_cls_i, 4'h0};
            if (cfg_wr_i) begin
                spv_q <= cfg_data_i[7:0];
                en_q  <= cfg_data_i[CFG_EN];
                sup_q <= cfg_data_i[CFG_SUP];
            end
        end
    end

    // Registered interrupt line and response / broadcast pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o          <= 1'b0;
            ack_valid_o    <= 1'b0;
            ack_none_o     <= 1'b0;
            ack_vec_o      <= '0;
            eoi_bc_valid_o <= 1'b0;
            eoi_bc_vec_o   <= '0;
        end else begin
            irq_o          <= deliver;
            ack_valid_o    <= ack_i;
            ack_none_o     <= ack_i && !deliver && !held;
            ack_vec_o      <= deliver ? irr_hi : (held ? spv_q : '0);
            eoi_bc_valid_o <= eoi_i && isr_found && tmr_q[isr_hi] && !sup_q;
            eoi_bc_vec_o   <= isr_hi;
        end
    end

    // R2
    ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr_o[7:4] >= tpr_q[7:4]) && (!isr_found || ppr_o[7:4] >= isr_hi[7:4]));

    // R3
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q));

    // R4
    spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && held && !req_valid_i && !eoi_i) |=>
            (irr_q == $past(irr_q)) && (isr_q == $past(isr_q)));

    // R5
    ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && deliver) |=> isr_q[ack_vec_o] && !ack_none_o);

    // R7
    bcast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid_o |-> $past(tmr_q[isr_hi]) && !$past(sup_q) && $past(eoi_i));

    // R4
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({deliver, held}));
endmodule

// File: tb/test_vec_prio_core.sv
`timescale 1ns/1ps
// Bench: model-driven sweeps of the vectored interrupt priority core.
module test_vec_prio_core;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_level = 0, ack = 0, eoi = 0;
    logic [7:0] req_vec = 0, tpr_data = 0;
    logic tpr_wr = 0, tpr_cls_wr = 0, cfg_wr = 0;
    logic [3:0] tpr_cls = 0;
    logic [15:0] cfg_data = 0;
    logic irq, ack_valid, ack_none, bc_valid;
    logic [7:0] ppr, ack_vec, bc_vec;

    int total = 0, bad = 0;
    bit done = 0;

    bit [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    int m_tpr = 0, m_spv = 8'hFF;
    bit m_en = 0, m_sup = 0;

    always #2.5 clk = ~clk;

    vec_prio_core i_vec_prio_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
        .ack_i(ack), .eoi_i(eoi),
        .tpr_wr_i(tpr_wr), .tpr_data_i(tpr_data),
        .tpr_cls_wr_i(tpr_cls_wr), .tpr_cls_i(tpr_cls),
        .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
        .irq_o(irq), .ppr_o(ppr),
        .ack_valid_o(ack_valid), .ack_none_o(ack_none), .ack_vec_o(ack_vec),
        .eoi_bc_valid_o(bc_valid), .eoi_bc_vec_o(bc_vec));

    function automatic int hi(bit [255:0] s);
        for (int i = 255; i >= 0; i--) if (s[i]) return i;
        return -1;
    endfunction

    function automatic int m_ppr();
        int c = hi(m_isr);
        if (c < 0) c = 0;
        c = c >> 4;
        return ((m_tpr >> 4) >= c) ? m_tpr : (c << 4);
    endfunction

    // 0 = nothing, 1 = deliverable, 2 = held off
    function automatic int m_pend();
        int r = hi(m_irr);
        int p = m_ppr();
        if (!m_en || r < 0) return 0;
        if (p != 0 && (r >> 4) <= (p >> 4)) return 2;
        return 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Second-negedge check of the registered line and priority (R10, R2).
    task automatic settle();
        @(negedge clk);
        chk("R10 irq", int'(irq), int'(m_pend() == 1));
        chk("R2 ppr", int'(ppr), m_ppr());
        chk("R5 ack pulse ends", int'(ack_valid), 0);
        chk("R7 bcast pulse ends", int'(bc_valid), 0);
    endtask

    task automatic t_accept(int v, bit lvl);
        req_valid = 1; req_vec = 8'(v); req_level = lvl;
        @(negedge clk);
        req_valid = 0;
        m_irr[v] = 1; m_tmr[v] = lvl;   // R6
        settle();
    endtask

    task automatic t_ack(bit with_req, int v);
        int p = m_pend();
        int h = hi(m_irr);
        ack = 1;
        if (with_req) begin req_valid = 1; req_vec = 8'(v); req_level = 0; end
        @(negedge clk);
        ack = 0; req_valid = 0;
        chk("R5 ack valid", int'(ack_valid), 1);
        chk("R3 ack none", int'(ack_none), int'(p == 0));
        if (p == 1) chk("R5 ack vector", int'(ack_vec), h);
        if (p == 2) chk("R4 spurious vector", int'(ack_vec), m_spv);
        if (p == 1) begin m_irr[h] = 0; m_isr[h] = 1; end
        if (with_req) begin m_irr[v] = 1; m_tmr[v] = 0; end  // R11
        settle();
    endtask

    task automatic t_eoi();
        int h = hi(m_isr);
        bit exp = (h >= 0) && m_tmr[h] && !m_sup;
        eoi = 1;
        @(negedge clk);
        eoi = 0;
        chk("R7 bcast valid", int'(bc_valid), int'(exp));
        if (exp) chk("R7 bcast vector", int'(bc_vec), h);
        if (h >= 0) m_isr[h] = 0;       // R8 when h < 0: nothing changes
        settle();
    endtask

    task automatic t_cfg(int d);
        cfg_wr = 1; cfg_data = 16'(d);
        @(negedge clk);
        cfg_wr = 0;
        m_spv = d & 8'hFF; m_en = d[8]; m_sup = d[12];
        settle();
    endtask

    task automatic t_tpr(bit full, int d, int cls);
        tpr_wr = full; tpr_data = 8'(d);
        tpr_cls_wr = 1; tpr_cls = 4'(cls);
        if (!full) tpr_cls_wr = 1;
        @(negedge clk);
        tpr_wr = 0; tpr_cls_wr = 0;
        m_tpr = full ? d : (cls << 4);  // R9
        settle();
    endtask

    // Retire everything in service and serve everything requested.
    task automatic drain();
        t_tpr(1, 0, 0);
        while (m_isr != 0) t_eoi();
        while (m_irr != 0) begin t_ack(0, 0); t_eoi(); end
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 ppr reset", int'(ppr), 0);
        chk("R1 ack reset", int'(ack_valid), 0);
        chk("R1 bcast reset", int'(bc_valid), 0);

        // R3 disabled: request never raises irq, ack returns none
        t_accept(8'h20, 0);
        t_ack(0, 0);
        // R8 retire on empty set
        t_eoi();
        t_cfg(16'h01FF);
        t_ack(0, 0);
        t_eoi();

        // R1 R5 R6: every vector alone, edge
        for (int v = 0; v < 256; v++) begin
            t_accept(v, 0);
            t_ack(0, 0);
            t_eoi();
        end

        // R6 R7: level vectors broadcast, suppressed ones do not
        for (int v = 16; v < 256; v += 37) begin
            t_accept(v, 1); t_ack(0, 0); t_eoi();
        end
        t_cfg(16'h11A5);
        for (int v = 20; v < 256; v += 41) begin
            t_accept(v, 1); t_ack(0, 0); t_eoi();
        end
        t_cfg(16'h01A5);

        // R2 R4 R9: every task class against every request class
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                t_tpr(t[0], (t << 4) | 3, t);
                t_accept((c << 4) | 5, c[0]);
                t_ack(0, 0);
                drain();
            end
        end

        // Nested vectors in different classes
        t_accept(8'h30, 1);
        t_ack(0, 0);
        t_accept(8'h50, 0);
        t_ack(0, 0);
        t_accept(8'h40, 1);
        t_ack(0, 0);          // held by 0x50 in service: spurious
        t_accept(8'h45, 0);
        t_eoi();              // retires 0x50
        t_ack(0, 0);          // 0x45 delivered
        t_ack(0, 0);          // 0x40 held by 0x45 in service
        t_eoi();              // retires 0x45
        t_ack(0, 0);          // 0x40
        t_eoi();              // 0x40 level: broadcast
        t_eoi();              // 0x30 level: broadcast
        t_eoi();              // empty (R8)

        // R11: accept the vector being acknowledged in the same cycle
        t_accept(8'h60, 0);
        t_ack(1, 8'h60);
        t_ack(0, 0);          // held: 0x60 in service
        t_eoi();
        t_ack(0, 0);
        t_eoi();

        // R9: short write alone, and full write beats short
        t_tpr(0, 0, 4'hA);
        t_tpr(1, 8'h37, 4'hC);
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule